// File: doc/BRIEF.md
# Remote Transaction Holding Buffer

This block sits beside the data cache of a multithreaded processor node and keeps track of every remote memory transaction that is still open. Each slot holds an address, a read-or-write flag, a mask of the hardware contexts waiting on it, a lifecycle state and one data word. Slots are found by address across the whole buffer, so a slot is never displaced by a conflict in the cache. A processor request to a new address takes a free slot and emits one outgoing network message. A read request from another context to an address whose transaction is still in flight joins that slot and sends no message. When the network reply arrives it fills the slot, and the slot stays locked until every context that waits on it has consumed the word.

Coherence invalidations that hit a locked slot are held back. The slot records a deferred flag. Once the last waiter consumes the data, the slot is released and a completion pulse reports the invalidation as done, together with its address. An invalidation that does not hit a locked slot is acknowledged at once.

Three ports follow valid/ready rules. On the request port, `req_ready` is computed from the presented context, address and kind. A low value means busy, and the processor keeps `req_valid` and its fields steady until a cycle with both high. On the response port, `rsp_ready` is always high: a reply is taken in the cycle it is valid, and a reply that matches no in-flight slot is discarded. On the consume port, `cons_ready` goes high in the same cycle as `cons_valid` only when the lookup hits, with `cons_data` valid alongside it. The consumer holds its request until the lookup hits. Network messages and invalidation acknowledgements are plain one-cycle strobes.

Top module: `rmt_txn_buf`

## Requirements
- R1: After reset every slot is free. `req_ready` is high for any context and address, and `msg_valid`, `cons_ready`, `inv_ack` and `inv_done` are low. `rsp_ready` is high.
- R2: A request whose address matches no live slot is accepted when a slot is free and its context is under its limit. In that same cycle `msg_valid` is high, with `msg_addr` and `msg_write` equal to the request's fields.
- R3: A request with the same address and kind as an in-flight slot (reply not yet arrived), from a context not already waiting on it, is accepted with no network message. Both contexts can later consume the same word.
- R4: A request is refused (`req_ready` low) if its address matches a locked slot, or matches an in-flight slot of the other kind, or matches a slot the same context already waits on. At most one live slot exists per address.
- R5: A request is refused if its context already has PER_CTX (default 2) live waits. A request for a new address is also refused when all ENTRIES slots are live.
- R6: A valid reply whose address matches an in-flight slot stores its data and locks that slot. A reply matching no in-flight slot is accepted and changes nothing.
- R7: A consume hits, with `cons_ready` high and `cons_data` equal to the stored word in the same cycle, only for a locked slot of that address on which the consuming context waits. Before the reply arrives, a consume misses.
- R8: A hit clears the consumer's wait. The slot becomes free at that clock edge only if no other context still waits on it, so a repeated consume by the same context misses and the address can be requested again.
- R9: An invalidation that does not hit a locked slot raises `inv_ack` for exactly the one cycle after it is presented.
- R10: An invalidation hitting a locked slot raises no `inv_ack`, and the locked data stays consumable. One cycle after the last waiter consumes the slot, `inv_done` pulses for one cycle with `inv_done_addr` equal to the slot's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Request can be taken (low means busy or colliding) |
| req_ctx | input | CXW | Requesting hardware context |
| req_addr | input | AW | Requested address |
| req_write | input | 1 | 1 for write, 0 for read |
| msg_valid | output | 1 | Outgoing network request strobe |
| msg_addr | output | AW | Address of outgoing request |
| msg_write | output | 1 | Kind of outgoing request |
| rsp_valid | input | 1 | Network reply present |
| rsp_ready | output | 1 | Reply taken (always high) |
| rsp_addr | input | AW | Reply address |
| rsp_data | input | DW | Reply data word |
| inv_valid | input | 1 | Coherence invalidation present |
| inv_addr | input | AW | Invalidated address |
| inv_ack | output | 1 | Immediate invalidation acknowledge, one cycle later |
| inv_done | output | 1 | Deferred invalidation completed |
| inv_done_addr | output | AW | Address of completed deferred invalidation |
| cons_valid | input | 1 | Consume lookup present |
| cons_ready | output | 1 | Consume hit |
| cons_ctx | input | CXW | Consuming context |
| cons_addr | input | AW | Consumed address |
| cons_data | output | DW | Stored data word on a hit |

## Verification
Request acceptance, the network message strobe and the consume hit with its data are all combinational, so the bench drives each input on a falling edge and samples those results a quarter period later, before the rising edge that commits the change. Slot changes take effect at that rising edge, so any follow-up request or consume is presented on the next falling edge. `inv_ack` and `inv_done` are registered: they are read a quarter period after the rising edge that took the invalidation or the final consume, and only there. Outgoing messages are also checked by a monitor that pops an expected-message queue filled by the request driver.

// File: rtl/tbuf_pkg.sv
package tbuf_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_INFLIGHT = 2'd1,
    SLOT_LOCKED = 2'd2
  } slot_state_e;
endpackage

// File: rtl/tbuf_first.sv
module tbuf_first #(
  parameter int N  = 16,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (vec[k]) begin
        found = 1'b1;
        idx   = IW'(k);
      end
    end
  end
endmodule

// File: rtl/tbuf_ctx_load.sv
module tbuf_ctx_load #(
  parameter int N    = 16,
  parameter int NCTX = 4,
  parameter int LW   = $clog2(N + 1)
) (
  input  logic [N-1:0][NCTX-1:0] waits,
  output logic [NCTX-1:0][LW-1:0] load
);
  always_comb begin
    for (int c = 0; c < NCTX; c++) begin
      load[c] = '0;
      for (int s = 0; s < N; s++) begin
        load[c] = load[c] + LW'(waits[s][c]);
      end
    end
  end
endmodule

// File: rtl/tbuf_slot.sv
module tbuf_slot
  import tbuf_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int NCTX = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc_en,
  input  logic [AW-1:0]   alloc_addr,
  input  logic            alloc_write,
  input  logic [NCTX-1:0] alloc_ctx,
  input  logic            merge_en,
  input  logic [NCTX-1:0] merge_ctx,
  input  logic            fill_en,
  input  logic [DW-1:0]   fill_data,
  input  logic            cons_en,
  input  logic [NCTX-1:0] cons_ctx,
  input  logic            inv_en,
  output slot_state_e     state_q,
  output logic [AW-1:0]   addr_q,
  output logic            write_q,
  output logic [DW-1:0]   data_q,
  output logic [NCTX-1:0] wait_q,
  output logic            done_q
);
  logic            inv_pend_q;
  logic [NCTX-1:0] wait_nx;

  always_comb begin
    wait_nx = wait_q;
    if (cons_en) wait_nx = wait_q & ~cons_ctx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= SLOT_FREE;
      addr_q     <= '0;
      write_q    <= 1'b0;
      data_q     <= '0;
      wait_q     <= '0;
      inv_pend_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        SLOT_FREE: begin
          if (alloc_en) begin
            state_q    <= SLOT_INFLIGHT;
            addr_q     <= alloc_addr;
            write_q    <= alloc_write;
            wait_q     <= alloc_ctx;
            inv_pend_q <= 1'b0;
          end
        end
        SLOT_INFLIGHT: begin
          if (merge_en) wait_q <= wait_q | merge_ctx;
          if (fill_en) begin
            state_q <= SLOT_LOCKED;
            data_q  <= fill_data;
          end
        end
        SLOT_LOCKED: begin
          wait_q <= wait_nx;
          if (inv_en) inv_pend_q <= 1'b1;
          if (wait_nx == '0) begin
            state_q    <= SLOT_FREE;
            inv_pend_q <= 1'b0;
            done_q     <= inv_pend_q | inv_en;
          end
        end
        default: state_q <= SLOT_FREE;
      endcase
    end
  end

  AST_FILL_ONLY_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> state_q == SLOT_INFLIGHT); // R6
  AST_LOCK_HAS_WAITER: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == SLOT_LOCKED |-> wait_q != '0); // R8
  AST_FREE_NO_WAITER: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == SLOT_FREE |-> wait_q == '0); // R8
  AST_INV_DEFERRED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SLOT_LOCKED && inv_en && wait_nx != '0) |=> (state_q == SLOT_LOCKED && inv_pend_q)); // R10
endmodule

// File: rtl/rmt_txn_buf.sv
module rmt_txn_buf
  import tbuf_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int NCTX    = 4,
  parameter int PER_CTX = 2,
  parameter int AW      = 32,
  parameter int DW      = 32,
  localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int CXW    = (NCTX > 1) ? $clog2(NCTX) : 1,
  localparam int LW     = $clog2(ENTRIES + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [CXW-1:0] req_ctx,
  input  logic [AW-1:0]  req_addr,
  input  logic           req_write,
  output logic           msg_valid,
  output logic [AW-1:0]  msg_addr,
  output logic           msg_write,
  input  logic           rsp_valid,
  output logic           rsp_ready,
  input  logic [AW-1:0]  rsp_addr,
  input  logic [DW-1:0]  rsp_data,
  input  logic           inv_valid,
  input  logic [AW-1:0]  inv_addr,
  output logic           inv_ack,
  output logic           inv_done,
  output logic [AW-1:0]  inv_done_addr,
  input  logic           cons_valid,
  output logic           cons_ready,
  input  logic [CXW-1:0] cons_ctx,
  input  logic [AW-1:0]  cons_addr,
  output logic [DW-1:0]  cons_data
);
  slot_state_e                st      [ENTRIES];
  logic [AW-1:0]              s_addr  [ENTRIES];
  logic [DW-1:0]              s_data  [ENTRIES];
  logic [ENTRIES-1:0]         s_write;
  logic [ENTRIES-1:0][NCTX-1:0] waits;
  logic [ENTRIES-1:0]         done_vec;

  logic [ENTRIES-1:0] free_vec, req_match, mergeable, fill_hit, cons_hit, inv_hit;
  logic [ENTRIES-1:0] alloc_en, merge_en;
  logic [NCTX-1:0][LW-1:0] load;
  logic [NCTX-1:0] req_ctx_oh, cons_ctx_oh;
  logic            free_found;
  logic [IW-1:0]   free_idx;
  logic            ctx_full, match_any, accept;
  logic            inv_ack_q;

  assign req_ctx_oh  = NCTX'(1) << req_ctx;
  assign cons_ctx_oh = NCTX'(1) << cons_ctx;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_lookup
    assign free_vec[i]  = (st[i] == SLOT_FREE);
    assign req_match[i] = (st[i] != SLOT_FREE) && (s_addr[i] == req_addr);
    assign mergeable[i] = req_match[i] && (st[i] == SLOT_INFLIGHT) &&
                          (s_write[i] == req_write) && !waits[i][req_ctx];
    assign fill_hit[i]  = rsp_valid && (st[i] == SLOT_INFLIGHT) && (s_addr[i] == rsp_addr);
    assign cons_hit[i]  = cons_valid && (st[i] == SLOT_LOCKED) &&
                          (s_addr[i] == cons_addr) && waits[i][cons_ctx];
    assign inv_hit[i]   = inv_valid && (st[i] == SLOT_LOCKED) && (s_addr[i] == inv_addr);
    assign alloc_en[i]  = accept && !match_any && free_found && (free_idx == IW'(i));
    assign merge_en[i]  = accept && mergeable[i];

    tbuf_slot #(.AW(AW), .DW(DW), .NCTX(NCTX)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_en   (alloc_en[i]),
      .alloc_addr (req_addr),
      .alloc_write(req_write),
      .alloc_ctx  (req_ctx_oh),
      .merge_en   (merge_en[i]),
      .merge_ctx  (req_ctx_oh),
      .fill_en    (fill_hit[i]),
      .fill_data  (rsp_data),
      .cons_en    (cons_hit[i]),
      .cons_ctx   (cons_ctx_oh),
      .inv_en     (inv_hit[i]),
      .state_q    (st[i]),
      .addr_q     (s_addr[i]),
      .write_q    (s_write[i]),
      .data_q     (s_data[i]),
      .wait_q     (waits[i]),
      .done_q     (done_vec[i])
    );
  end

  tbuf_first #(.N(ENTRIES), .IW(IW)) u_free (
    .vec  (free_vec),
    .found(free_found),
    .idx  (free_idx)
  );

  tbuf_ctx_load #(.N(ENTRIES), .NCTX(NCTX), .LW(LW)) u_load (
    .waits(waits),
    .load (load)
  );

  assign ctx_full  = load[req_ctx] >= LW'(PER_CTX);
  assign match_any = |req_match;
  assign req_ready = !ctx_full && (match_any ? (|mergeable) : free_found);
  assign accept    = req_valid && req_ready;

  assign msg_valid = accept && !match_any;
  assign msg_addr  = req_addr;
  assign msg_write = req_write;

  assign rsp_ready  = 1'b1;
  assign cons_ready = |cons_hit;

  always_comb begin
    cons_data     = '0;
    inv_done_addr = '0;
    for (int s = 0; s < ENTRIES; s++) begin
      if (cons_hit[s]) cons_data = cons_data | s_data[s];
      if (done_vec[s]) inv_done_addr = inv_done_addr | s_addr[s];
    end
  end

  assign inv_done = |done_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) inv_ack_q <= 1'b0;
    else        inv_ack_q <= inv_valid && !(|inv_hit);
  end
  assign inv_ack = inv_ack_q;

  logic over_limit;
  always_comb begin
    over_limit = 1'b0;
    for (int c = 0; c < NCTX; c++) begin
      if (load[c] > LW'(PER_CTX)) over_limit = 1'b1;
    end
  end

  AST_CTX_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !over_limit); // R5
  AST_ONE_SLOT_PER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_match)); // R4
  AST_DONE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_vec)); // R10
  AST_ACK_FOLLOWS_INV: assert property (@(posedge clk) disable iff (!rst_n)
    inv_ack |-> $past(inv_valid)); // R9
  AST_SINGLE_CONSUME_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cons_hit)); // R7
endmodule

// File: tb/rmt_txn_buf_tb.sv
`timescale 1ns/1ps
module rmt_txn_buf_tb;
  localparam int ENT = 6;
  localparam int AW  = 16;
  localparam int DW  = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          req_valid = 0, req_write = 0;
  logic [1:0]    req_ctx = 0;
  logic [AW-1:0] req_addr = 0;
  logic          req_ready, msg_valid, msg_write;
  logic [AW-1:0] msg_addr;
  logic          rsp_valid = 0;
  logic          rsp_ready;
  logic [AW-1:0] rsp_addr = 0;
  logic [DW-1:0] rsp_data = 0;
  logic          inv_valid = 0;
  logic [AW-1:0] inv_addr = 0;
  logic          inv_ack, inv_done;
  logic [AW-1:0] inv_done_addr;
  logic          cons_valid = 0;
  logic          cons_ready;
  logic [1:0]    cons_ctx = 0;
  logic [AW-1:0] cons_addr = 0;
  logic [DW-1:0] cons_data;

  rmt_txn_buf #(.ENTRIES(ENT), .NCTX(4), .PER_CTX(2), .AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_ctx(req_ctx),
    .req_addr(req_addr), .req_write(req_write),
    .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_write(msg_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_data(rsp_data),
    .inv_valid(inv_valid), .inv_addr(inv_addr), .inv_ack(inv_ack),
    .inv_done(inv_done), .inv_done_addr(inv_done_addr),
    .cons_valid(cons_valid), .cons_ready(cons_ready), .cons_ctx(cons_ctx),
    .cons_addr(cons_addr), .cons_data(cons_data)
  );

  int total = 0;
  int bad = 0;
  logic [AW:0] msg_q[$];

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected network messages as the design emits them
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (rst_n && msg_valid) begin
        if (msg_q.size() == 0) chk("R2 unexpected message", {47'd0, msg_write, msg_addr}, 64'hFFFF);
        else chk("R2 message fields", {47'd0, msg_write, msg_addr}, {47'd0, msg_q.pop_front()});
      end
    end
  end

  task automatic do_req(int ctx, logic [AW-1:0] a, bit wr, bit exp_rdy, bit exp_msg, string tag);
    @(negedge clk);
    req_valid = 1; req_ctx = ctx[1:0]; req_addr = a; req_write = wr;
    if (exp_msg) msg_q.push_back({wr, a});
    #5;
    chk(tag, {63'd0, req_ready}, {63'd0, exp_rdy});
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic do_rsp(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    rsp_valid = 1; rsp_addr = a; rsp_data = d;
    #5;
    chk("R6 reply taken", {63'd0, rsp_ready}, 64'd1);
    @(posedge clk); #1;
    rsp_valid = 0;
  endtask

  task automatic do_cons(int ctx, logic [AW-1:0] a, bit exp_rdy, logic [DW-1:0] exp_d,
                         bit exp_done, string tag);
    @(negedge clk);
    cons_valid = 1; cons_ctx = ctx[1:0]; cons_addr = a;
    #5;
    chk(tag, {63'd0, cons_ready}, {63'd0, exp_rdy});
    if (exp_rdy) chk({tag, " data"}, {32'd0, cons_data}, {32'd0, exp_d});
    @(posedge clk); #1;
    cons_valid = 0;
    #4;
    chk("R10 done pulse", {63'd0, inv_done}, {63'd0, exp_done});
    if (exp_done) chk("R10 done address", {48'd0, inv_done_addr}, {48'd0, a});
  endtask

  task automatic do_inv(logic [AW-1:0] a, bit exp_ack, string tag);
    @(negedge clk);
    inv_valid = 1; inv_addr = a;
    @(posedge clk); #1;
    inv_valid = 0;
    #4;
    chk(tag, {63'd0, inv_ack}, {63'd0, exp_ack});
  endtask

  localparam logic [AW-1:0] A = 16'h0100, B = 16'h0200, C = 16'h0300;
  localparam logic [AW-1:0] X1 = 16'h0400, X2 = 16'h0410, Y1 = 16'h0500, Y2 = 16'h0510, Z = 16'h0600;

  initial begin
    #(20 * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk); #5;
    chk("R1 ready after reset", {63'd0, req_ready}, 64'd1);
    chk("R1 no message", {63'd0, msg_valid}, 64'd0);
    chk("R1 no consume hit", {63'd0, cons_ready}, 64'd0);
    chk("R1 no ack", {62'd0, inv_ack, inv_done}, 64'd0);
    chk("R1 reply ready", {63'd0, rsp_ready}, 64'd1);

    do_req(0, A, 0, 1, 1, "R2 new request");
    do_req(1, A, 0, 1, 0, "R3 merge other context");
    do_req(0, A, 0, 0, 0, "R4 same context twice");
    do_req(2, A, 1, 0, 0, "R4 kind mismatch");
    do_cons(0, A, 0, '0, 0, "R7 consume before reply");
    do_rsp(A, 32'hCAFE0001);
    do_req(3, A, 0, 0, 0, "R4 locked collision");
    do_inv(A, 0, "R10 deferred no ack");
    do_cons(0, A, 1, 32'hCAFE0001, 0, "R7 first consumer");
    do_cons(0, A, 0, '0, 0, "R8 repeat consume misses");
    do_cons(1, A, 1, 32'hCAFE0001, 1, "R3 merged consumer");
    do_req(0, A, 0, 1, 1, "R8 slot freed");

    do_rsp(B, 32'h0BAD0BAD);
    do_req(2, B, 0, 1, 1, "R6 stray reply dropped");
    do_cons(2, B, 0, '0, 0, "R6 no fill from stray");
    do_inv(B, 1, "R9 inflight inval acked");
    do_inv(C, 1, "R9 unknown inval acked");

    do_req(3, X1, 0, 1, 1, "R5 ctx first");
    do_req(3, X2, 1, 1, 1, "R2 write message");
    do_req(3, C, 0, 0, 0, "R5 ctx limit");
    do_req(1, Y1, 0, 1, 1, "R2 fifth slot");
    do_req(1, Y2, 0, 1, 1, "R2 sixth slot");
    do_req(0, Z, 0, 0, 0, "R5 buffer full");
    do_rsp(Y1, 32'h0000BEEF);
    do_cons(1, Y1, 1, 32'h0000BEEF, 0, "R7 plain consume");
    do_req(0, Z, 0, 1, 1, "R8 space after free");

    @(negedge clk); @(negedge clk); #5;
    chk("R2 all messages seen", 64'(msg_q.size()), 64'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule